// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block is a circular buffer of in-flight instruction results. Instructions may finish out of order, and the buffer lets them update architectural state only in program order. Dispatch claims the slot at the tail. The index of that slot is handed back as the tag under which the instruction's result will later be delivered. Execution units write a value and its completion flags into the slot named by a tag. Each cycle, the oldest slot retires if it is complete, and at most one slot retires per cycle. Depending on its class, the retiring slot asks for a register write or releases a store.

Decode can search the buffer by register number. The search returns the youngest in-flight producer of that register, with its value and a flag saying whether the value is present yet. Once a producer has retired, the search no longer finds it, and the value must come from the register file.

A slot that completes with a fault, or a branch that completes as mispredicted, takes effect only when it becomes the oldest slot. In that cycle it retires without touching architectural state, and every younger slot is discarded. The tail moves to the slot just after it, so the buffer is empty on the next cycle.

Top module: `rob_core`

## Requirements
- R1: After synchronous reset the buffer is empty: `disp_ready` is 1, `disp_tag` is 0, `cm_fire` is 0 and no lookup hits.
- R2: Each accepted dispatch receives as its tag the current tail index. Tags of successive accepted dispatches increase by one, modulo DEPTH.
- R3: When DEPTH slots are occupied, `disp_ready` is 0 and a dispatch request is not accepted: the tail tag does not change.
- R4: The oldest slot retires only after its result has been written. A younger completed slot waits behind an incomplete older one.
- R5: Retirement is in program order, at most one slot per cycle. Class encoding on `disp_kind`: 0 = register result (`cm_reg_we` at retire), 1 = store (`cm_store_go` at retire), 2 = branch (neither). `cm_dest` and `cm_value` carry the slot's destination and result.
- R6: Each lookup port returns `lk_hit`=1 with the ready flag and value of the youngest occupied class-0 slot whose destination matches the queried register. It returns `lk_hit`=0 when no occupied slot matches, including after the producer has retired. A lookup sees results written at earlier clock edges only.
- R7: A slot completed with `wb_excp`=1 retires with `cm_excp`=1 and `cm_flush`=1 and with neither `cm_reg_we` nor `cm_store_go`. All younger slots are discarded and never retire, and the next tag handed out is its own tag plus one.
- R8: A slot completed with `wb_mispred`=1 retires with `cm_flush`=1. All younger slots are discarded, and the next tag handed out is its own tag plus one.
- R9: In a cycle where `cm_flush` is 1, `disp_ready` is 0.
- R10: Head and tail indices wrap past DEPTH-1 to 0. Full and empty stay correct across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_kind | input | 2 | Class of dispatched instruction (0 reg, 1 store, 2 branch) |
| disp_dest | input | REG_W | Destination register of dispatched instruction |
| disp_ready | output | 1 | A free slot is available and no flush is under way |
| disp_tag | output | log2(DEPTH) | Tag that the next accepted dispatch receives |
| wb_valid | input | 1 | Result write strobe |
| wb_tag | input | log2(DEPTH) | Slot receiving the result |
| wb_value | input | DATA_W | Result value |
| wb_excp | input | 1 | Instruction raised a fault |
| wb_mispred | input | 1 | Branch resolved as mispredicted |
| lk_reg | input | NUM_LK*REG_W | Registers queried, one field per port |
| lk_hit | output | NUM_LK | An in-flight producer was found |
| lk_ready | output | NUM_LK | The producer's value is present |
| lk_value | output | NUM_LK*DATA_W | Producer value, one field per port |
| cm_fire | output | 1 | Oldest slot retires this cycle |
| cm_reg_we | output | 1 | Retirement writes a register |
| cm_store_go | output | 1 | Retirement releases a store |
| cm_excp | output | 1 | Retiring slot carries a fault |
| cm_flush | output | 1 | Younger slots are being discarded |
| cm_dest | output | REG_W | Destination of retiring slot |
| cm_value | output | DATA_W | Value of retiring slot |

## Verification
The checker assumes that execution units only write tags that are currently occupied, and that each occupied slot is written at most once. It also assumes that a dispatch is presented only while `disp_ready` is high, except in the deliberate full-buffer probe, which the design must ignore. The directed stimulus keeps a bench-side copy of the expected tail tag. It writes back only tags it has received from dispatch and not yet seen retire or be squashed. Out-of-order completion is produced by writing younger slots before the oldest one.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef enum logic [1:0] {
        ROB_K_REG    = 2'd0,
        ROB_K_STORE  = 2'd1,
        ROB_K_BRANCH = 2'd2
    } rob_kind_e;

    function automatic logic kind_writes_reg(rob_kind_e k);
        return k == ROB_K_REG;
    endfunction

    function automatic logic kind_is_store(rob_kind_e k);
        return k == ROB_K_STORE;
    endfunction

endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc,
    input  logic             retire,
    input  logic             flush,
    output logic [CNT_W-1:0] head_q,
    output logic [CNT_W-1:0] tail_q,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    // extra top bit on each pointer separates full from empty
    assign count = tail_q - head_q;
    assign full  = count == CNT_W'(DEPTH);
    assign empty = count == '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
        end else if (retire && flush) begin
            head_q <= head_q + 1'b1;
            tail_q <= head_q + 1'b1;
        end else begin
            if (retire) head_q <= head_q + 1'b1;
            if (alloc)  tail_q <= tail_q + 1'b1;
        end
    end
endmodule

// File: rtl/rob_lookup.sv
module rob_lookup
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int REG_W  = 5,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic [IDX_W-1:0]  head_idx,
    input  logic [CNT_W-1:0]  count,
    input  rob_kind_e         kind_q [DEPTH],
    input  logic [REG_W-1:0]  dest_q [DEPTH],
    input  logic [DATA_W-1:0] val_q  [DEPTH],
    input  logic              rdy_q  [DEPTH],
    input  logic [REG_W-1:0]  query,
    output logic              hit,
    output logic              ready,
    output logic [DATA_W-1:0] value
);
    // walk oldest to youngest; a later match overrides an earlier one
    always_comb begin
        logic [IDX_W-1:0] slot;
        hit   = 1'b0;
        ready = 1'b0;
        value = '0;
        for (int i = 0; i < DEPTH; i++) begin
            slot = head_idx + IDX_W'(i);
            if (CNT_W'(i) < count && kind_writes_reg(kind_q[slot]) &&
                dest_q[slot] == query) begin
                hit   = 1'b1;
                ready = rdy_q[slot];
                value = val_q[slot];
            end
        end
    end
endmodule

// File: rtl/rob_core.sv
module rob_core
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int REG_W  = 5,
    parameter int DATA_W = 32,
    parameter int NUM_LK = 2,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     disp_valid,
    input  logic [1:0]               disp_kind,
    input  logic [REG_W-1:0]         disp_dest,
    output logic                     disp_ready,
    output logic [IDX_W-1:0]         disp_tag,
    input  logic                     wb_valid,
    input  logic [IDX_W-1:0]         wb_tag,
    input  logic [DATA_W-1:0]        wb_value,
    input  logic                     wb_excp,
    input  logic                     wb_mispred,
    input  logic [NUM_LK*REG_W-1:0]  lk_reg,
    output logic [NUM_LK-1:0]        lk_hit,
    output logic [NUM_LK-1:0]        lk_ready,
    output logic [NUM_LK*DATA_W-1:0] lk_value,
    output logic                     cm_fire,
    output logic                     cm_reg_we,
    output logic                     cm_store_go,
    output logic                     cm_excp,
    output logic                     cm_flush,
    output logic [REG_W-1:0]         cm_dest,
    output logic [DATA_W-1:0]        cm_value
);
    logic [CNT_W-1:0] head_q, tail_q, count;
    logic             full, empty;
    logic [IDX_W-1:0] head_idx, tail_idx, wb_off;
    logic             alloc, head_done, head_squash, wb_live;

    rob_kind_e         kind_q [DEPTH];
    logic [REG_W-1:0]  dest_q [DEPTH];
    logic [DATA_W-1:0] val_q  [DEPTH];
    logic              rdy_q  [DEPTH];
    logic              exc_q  [DEPTH];
    logic              mis_q  [DEPTH];

    assign head_idx = head_q[IDX_W-1:0];
    assign tail_idx = tail_q[IDX_W-1:0];

    // oldest slot state drives retirement
    assign head_done   = !empty && rdy_q[head_idx];
    assign head_squash = head_done && (exc_q[head_idx] || mis_q[head_idx]);

    assign disp_ready = !full && !head_squash;
    assign disp_tag   = tail_idx;
    assign alloc      = disp_valid && disp_ready;

    // a result only lands in a slot between head and tail
    assign wb_off  = wb_tag - head_idx;
    assign wb_live = wb_valid && ({1'b0, wb_off} < count);

    rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk    (clk),
        .rst    (rst),
        .alloc  (alloc),
        .retire (head_done),
        .flush  (head_squash),
        .head_q (head_q),
        .tail_q (tail_q),
        .count  (count),
        .full   (full),
        .empty  (empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                rdy_q[i] <= 1'b0;
                exc_q[i] <= 1'b0;
                mis_q[i] <= 1'b0;
            end
        end else begin
            if (alloc) begin
                kind_q[tail_idx] <= rob_kind_e'(disp_kind);
                dest_q[tail_idx] <= disp_dest;
                rdy_q[tail_idx]  <= 1'b0;
                exc_q[tail_idx]  <= 1'b0;
                mis_q[tail_idx]  <= 1'b0;
            end
            if (wb_live) begin
                val_q[wb_tag] <= wb_value;
                rdy_q[wb_tag] <= 1'b1;
                exc_q[wb_tag] <= wb_excp;
                mis_q[wb_tag] <= wb_mispred;
            end
        end
    end

    assign cm_fire     = head_done;
    assign cm_flush    = head_squash;
    assign cm_excp     = head_done && exc_q[head_idx];
    assign cm_reg_we   = head_done && !exc_q[head_idx] && kind_writes_reg(kind_q[head_idx]);
    assign cm_store_go = head_done && !exc_q[head_idx] && kind_is_store(kind_q[head_idx]);
    assign cm_dest     = dest_q[head_idx];
    assign cm_value    = val_q[head_idx];

    for (genvar p = 0; p < NUM_LK; p++) begin : g_lk
        rob_lookup #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) u_lk (
            .head_idx (head_idx),
            .count    (count),
            .kind_q   (kind_q),
            .dest_q   (dest_q),
            .val_q    (val_q),
            .rdy_q    (rdy_q),
            .query    (lk_reg[p*REG_W +: REG_W]),
            .hit      (lk_hit[p]),
            .ready    (lk_ready[p]),
            .value    (lk_value[p*DATA_W +: DATA_W])
        );
    end
endmodule

// File: rtl/rob_core_checker.sv
module rob_core_checker #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             disp_valid,
    input logic             disp_ready,
    input logic [IDX_W-1:0] disp_tag,
    input logic             cm_fire,
    input logic             cm_flush,
    input logic             wb_valid,
    input logic             wb_live,
    input logic             alloc,
    input logic [CNT_W-1:0] count
);
    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> count == '0);

    assert_tag_step_R2: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && disp_ready && !cm_flush) |=> disp_tag == IDX_W'($past(disp_tag) + 1'b1));

    assert_full_blocks_R3: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_W'(DEPTH)) |-> !disp_ready);

    assert_retire_nonempty_R4: assert property (@(posedge clk) disable iff (rst)
        cm_fire |-> count != '0);

    // input assumption: results only target occupied slots
    assert_wb_targets_live_R4: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> wb_live);

    assert_retire_one_R5: assert property (@(posedge clk) disable iff (rst)
        (cm_fire && !cm_flush && !alloc) |=> count == $past(count) - 1'b1);

    assert_flush_empties_R7: assert property (@(posedge clk) disable iff (rst)
        cm_flush |=> count == '0);

    assert_flush_blocks_R9: assert property (@(posedge clk) disable iff (rst)
        cm_flush |-> !disp_ready);
endmodule

bind rob_core rob_core_checker #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .disp_valid (disp_valid),
    .disp_ready (disp_ready),
    .disp_tag   (disp_tag),
    .cm_fire    (cm_fire),
    .cm_flush   (cm_flush),
    .wb_valid   (wb_valid),
    .wb_live    (wb_live),
    .alloc      (alloc),
    .count      (count)
);

// File: tb/test_rob_core.sv
module test_rob_core;
    localparam int DEPTH  = 8;
    localparam int REG_W  = 5;
    localparam int DATA_W = 32;
    localparam int NUM_LK = 2;
    localparam int IDX_W  = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic disp_valid = 1'b0;
    logic [1:0] disp_kind = 2'd0;
    logic [REG_W-1:0] disp_dest = '0;
    logic disp_ready;
    logic [IDX_W-1:0] disp_tag;
    logic wb_valid = 1'b0;
    logic [IDX_W-1:0] wb_tag = '0;
    logic [DATA_W-1:0] wb_value = '0;
    logic wb_excp = 1'b0;
    logic wb_mispred = 1'b0;
    logic [NUM_LK*REG_W-1:0] lk_reg = '0;
    logic [NUM_LK-1:0] lk_hit, lk_ready;
    logic [NUM_LK*DATA_W-1:0] lk_value;
    logic cm_fire, cm_reg_we, cm_store_go, cm_excp, cm_flush;
    logic [REG_W-1:0] cm_dest;
    logic [DATA_W-1:0] cm_value;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [IDX_W-1:0] exp_tag = '0;

    always #2.5 clk = ~clk;

    rob_core #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .NUM_LK(NUM_LK)) i_rob_core (
        .clk(clk), .rst(rst),
        .disp_valid(disp_valid), .disp_kind(disp_kind), .disp_dest(disp_dest),
        .disp_ready(disp_ready), .disp_tag(disp_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value),
        .wb_excp(wb_excp), .wb_mispred(wb_mispred),
        .lk_reg(lk_reg), .lk_hit(lk_hit), .lk_ready(lk_ready), .lk_value(lk_value),
        .cm_fire(cm_fire), .cm_reg_we(cm_reg_we), .cm_store_go(cm_store_go),
        .cm_excp(cm_excp), .cm_flush(cm_flush), .cm_dest(cm_dest), .cm_value(cm_value)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic disp(input logic [1:0] k, input logic [REG_W-1:0] d, output logic [IDX_W-1:0] t);
        @(negedge clk);
        disp_valid = 1'b1;
        disp_kind  = k;
        disp_dest  = d;
        t = disp_tag;
        chk("R2", "dispatch tag", t, exp_tag);
        chk("R2", "dispatch ready", disp_ready, 1);
        step();
        disp_valid = 1'b0;
        exp_tag = exp_tag + 1'b1;
    endtask

    task automatic wb(input logic [IDX_W-1:0] t, input logic [DATA_W-1:0] v, input logic e, input logic m);
        @(negedge clk);
        wb_valid = 1'b1; wb_tag = t; wb_value = v; wb_excp = e; wb_mispred = m;
        step();
        wb_valid = 1'b0; wb_excp = 1'b0; wb_mispred = 1'b0;
    endtask

    task automatic look(input int p, input logic [REG_W-1:0] r);
        lk_reg[p*REG_W +: REG_W] = r;
        #0.5;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "ready", disp_ready, 1);
        chk("R1", "tag", disp_tag, 0);
        chk("R1", "fire", cm_fire, 0);
        look(0, 5'd0);
        chk("R1", "lookup hit", lk_hit[0], 0);
    endtask

    task automatic t_inorder();
        logic [IDX_W-1:0] ta, tb, tc;
        disp(2'd0, 5'd3, ta);
        disp(2'd0, 5'd4, tb);
        disp(2'd1, 5'd0, tc);
        wb(tb, 32'h44, 0, 0);
        chk("R4", "younger done, no retire", cm_fire, 0);
        look(0, 5'd4);
        chk("R6", "r4 hit", lk_hit[0], 1);
        chk("R6", "r4 ready", lk_ready[0], 1);
        chk("R6", "r4 value", lk_value[DATA_W-1:0], 32'h44);
        look(0, 5'd3);
        chk("R6", "r3 hit", lk_hit[0], 1);
        chk("R6", "r3 not ready", lk_ready[0], 0);
        wb(ta, 32'h33, 0, 0);
        chk("R5", "A fire", cm_fire, 1);
        chk("R5", "A reg_we", cm_reg_we, 1);
        chk("R5", "A dest", cm_dest, 3);
        chk("R5", "A value", cm_value, 32'h33);
        step();
        chk("R5", "B fire", cm_fire, 1);
        chk("R5", "B dest", cm_dest, 4);
        chk("R5", "B value", cm_value, 32'h44);
        step();
        chk("R4", "store pending", cm_fire, 0);
        wb(tc, 32'h55, 0, 0);
        chk("R5", "store go", cm_store_go, 1);
        chk("R5", "store no reg_we", cm_reg_we, 0);
        chk("R5", "store value", cm_value, 32'h55);
        step();
        chk("R5", "drained", cm_fire, 0);
        look(0, 5'd4);
        chk("R6", "retired not found", lk_hit[0], 0);
    endtask

    task automatic t_youngest();
        logic [IDX_W-1:0] th, tx, ty;
        disp(2'd2, 5'd0, th);
        disp(2'd0, 5'd5, tx);
        disp(2'd0, 5'd5, ty);
        wb(tx, 32'd11, 0, 0);
        look(0, 5'd5);
        chk("R6", "youngest hit", lk_hit[0], 1);
        chk("R6", "youngest not ready", lk_ready[0], 0);
        wb(ty, 32'd22, 0, 0);
        look(1, 5'd5);
        chk("R6", "port1 hit", lk_hit[1], 1);
        chk("R6", "port1 ready", lk_ready[1], 1);
        chk("R6", "port1 value", lk_value[2*DATA_W-1:DATA_W], 22);
        wb(th, 32'd0, 0, 0);
        chk("R5", "branch fire", cm_fire, 1);
        chk("R5", "branch no reg_we", cm_reg_we, 0);
        chk("R5", "branch no store", cm_store_go, 0);
        chk("R5", "branch no flush", cm_flush, 0);
        step();
        chk("R5", "X value", cm_value, 11);
        step();
        chk("R5", "Y value", cm_value, 22);
        step();
        chk("R5", "empty", cm_fire, 0);
    endtask

    task automatic t_full_wrap();
        logic [IDX_W-1:0] tags [DEPTH];
        for (int i = 0; i < DEPTH; i++) disp(2'd0, REG_W'(i + 8), tags[i]);
        chk("R10", "wrapped tag", tags[2], 0);
        #0.5;
        chk("R3", "full ready", disp_ready, 0);
        @(negedge clk);
        disp_valid = 1'b1;
        step();
        disp_valid = 1'b0;
        chk("R3", "tag held", disp_tag, exp_tag);
        chk("R3", "still full", disp_ready, 0);
        for (int j = DEPTH - 1; j >= 1; j--) wb(tags[j], DATA_W'(100 + j), 0, 0);
        chk("R4", "held behind head", cm_fire, 0);
        wb(tags[0], 32'd100, 0, 0);
        for (int i = 0; i < DEPTH; i++) begin
            chk("R5", "ordered fire", cm_fire, 1);
            chk("R5", "ordered dest", cm_dest, i + 8);
            chk("R10", "ordered value", cm_value, 100 + i);
            step();
        end
        chk("R10", "empty after wrap", cm_fire, 0);
        chk("R10", "ready after wrap", disp_ready, 1);
    endtask

    task automatic t_exception();
        logic [IDX_W-1:0] te, tf, tg;
        disp(2'd0, 5'd6, te);
        disp(2'd0, 5'd7, tf);
        disp(2'd1, 5'd0, tg);
        wb(tf, 32'd7, 0, 0);
        wb(tg, 32'd9, 0, 0);
        wb(te, 32'd0, 1, 0);
        chk("R7", "fire", cm_fire, 1);
        chk("R7", "excp", cm_excp, 1);
        chk("R7", "no reg_we", cm_reg_we, 0);
        chk("R7", "no store", cm_store_go, 0);
        chk("R7", "flush", cm_flush, 1);
        chk("R9", "ready low in flush", disp_ready, 0);
        step();
        exp_tag = te + 1'b1;
        chk("R7", "younger squashed", cm_fire, 0);
        chk("R7", "next tag", disp_tag, exp_tag);
        look(0, 5'd7);
        chk("R7", "squashed not found", lk_hit[0], 0);
    endtask

    task automatic t_mispredict();
        logic [IDX_W-1:0] tbr, tk;
        disp(2'd2, 5'd0, tbr);
        disp(2'd0, 5'd8, tk);
        wb(tk, 32'h88, 0, 0);
        wb(tbr, 32'd0, 0, 1);
        chk("R8", "fire", cm_fire, 1);
        chk("R8", "flush", cm_flush, 1);
        chk("R8", "no reg_we", cm_reg_we, 0);
        step();
        exp_tag = tbr + 1'b1;
        chk("R8", "younger squashed", cm_fire, 0);
        chk("R8", "next tag", disp_tag, exp_tag);
        look(0, 5'd8);
        chk("R8", "squashed not found", lk_hit[0], 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_inorder();
        t_youngest();
        t_full_wrap();
        t_exception();
        t_mispredict();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule